// File: doc/BRIEF.md
# Over-Voltage Fault Supervisor

This block supervises the two gate-drive outputs of a switching stage when an output over-voltage fault occurs. It takes four comparator flags, already synchronised to its clock: over-voltage present, over-voltage cleared, reference good (at or above 90% of nominal) and reference low (at or below 20% of nominal). It also takes two asynchronous PWM commands. Its outputs are the two driver levels, a reference-discharge enable and a one-cycle soft-start request.

The supervisor has three modes. In start-up mode, which lasts while the reference is not yet good, an over-voltage only blanks the drivers. In normal mode, an over-voltage must last across five consecutive PWM switching events before it is latched as a fault. A switching event is a rising edge on either command. While the fault is latched, both drivers are forced to a level chosen at build time and the reference is discharged. The fault is released only once the reference has fallen low and the over-voltage has cleared. On release, a soft-start is requested and the supervisor goes back to start-up mode.

Top module: `ovp_supervisor`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters start-up mode with the event count at zero and no fault latched. `drive_a`, `drive_b`, `ref_discharge` and `soft_start` are all 0 once that edge has passed.
- R2: In start-up mode with no over-voltage seen, each of `drive_a` and `drive_b` equals its PWM input delayed by two clock edges (a two-flop synchronizer).
- R3: In start-up mode, `ov_flag` high forces both drivers to 0 at once. They stay 0 after `ov_flag` falls, until `ref_good` moves the block into normal mode. `ref_discharge` stays 0 throughout.
- R4: In normal mode, with `ov_flag` held high, the fifth switching event latches the fault. `ref_discharge` rises on the clock edge that follows the cycle in which the synchronised edge was seen, which is three edges after the PWM input rises.
- R5: In normal mode, any cycle with `ov_flag` low resets the event count to zero, so five further events are needed.
- R6: Rising edges on both PWM inputs in the same cycle count as one event. Falling edges count as none.
- R7: While the fault is latched, `ref_discharge` is 1 and both drivers equal the `FORCE_HIGH` parameter (1 gives high, 0 gives low), whatever the PWM inputs do.
- R8: The fault is held until `ref_low` and `ov_clear` are both 1 in the same cycle. Either flag alone has no effect.
- R9: On release, `soft_start` is 1 for exactly one cycle, `ref_discharge` drops in that same cycle, and the block is back in start-up mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_a_in | input | 1 | PWM command A, asynchronous |
| pwm_b_in | input | 1 | PWM command B, asynchronous |
| ov_flag | input | 1 | Over-voltage present |
| ov_clear | input | 1 | Over-voltage cleared |
| ref_good | input | 1 | Reference at or above 90% of nominal |
| ref_low | input | 1 | Reference at or below 20% of nominal |
| drive_a | output | 1 | Driver output A |
| drive_b | output | 1 | Driver output B |
| ref_discharge | output | 1 | Reference discharge enable |
| soft_start | output | 1 | One-cycle soft-start request |

## Verification
The embedded assertions check the following on every cycle:
- a fault latch only ever follows a switching event seen with the over-voltage present;
- the forced driver level holds for as long as the discharge is on;
- a release happens only with both exit flags set;
- the soft-start request is a single-cycle pulse;
- a low over-voltage flag empties the event count;
- the start-up blanking keeps the drivers low.

Other behaviours need multi-cycle scenarios in the bench, because they depend on how many events were seen rather than on one cycle. These are:
- exactly five events are needed;
- a single low cycle restarts the count;
- coincident edges count once;
- the start-up hold lasts after the flag falls.

// File: rtl/ovp_supervisor.sv
module ovp_supervisor #(
  parameter int FILTER_COUNT = 5,
  parameter bit FORCE_HIGH   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_a_in,
  input  logic pwm_b_in,
  input  logic ov_flag,
  input  logic ov_clear,
  input  logic ref_good,
  input  logic ref_low,
  output logic drive_a,
  output logic drive_b,
  output logic ref_discharge,
  output logic soft_start
);
  localparam int CW = $clog2(FILTER_COUNT + 1);
  localparam logic [CW-1:0] LAST = CW'(FILTER_COUNT - 1);

  typedef enum logic [1:0] {ST_STARTUP, ST_NORMAL, ST_FAULT} mode_t;

  mode_t mode;
  logic [CW-1:0] cnt;
  logic [2:0] sa, sb;
  logic hold, ss_q;
  logic ev, release_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      sa <= '0;
      sb <= '0;
    end else begin
      sa <= {sa[1:0], pwm_a_in};
      sb <= {sb[1:0], pwm_b_in};
    end
  end

  assign ev = (sa[1] & ~sa[2]) | (sb[1] & ~sb[2]);
  assign release_ok = ref_low & ov_clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= ST_STARTUP;
      cnt  <= '0;
      hold <= 1'b0;
      ss_q <= 1'b0;
    end else begin
      ss_q <= 1'b0;
      case (mode)
        ST_STARTUP: begin
          cnt <= '0;
          if (ref_good) begin
            mode <= ST_NORMAL;
            hold <= 1'b0;
          end else if (ov_flag) begin
            hold <= 1'b1;
          end
        end
        ST_NORMAL: begin
          if (!ov_flag) cnt <= '0;
          else if (ev) begin
            if (cnt == LAST) begin
              mode <= ST_FAULT;
              cnt  <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_FAULT: begin
          if (release_ok) begin
            mode <= ST_STARTUP;
            ss_q <= 1'b1;
            hold <= 1'b0;
          end
        end
        default: mode <= ST_STARTUP;
      endcase
    end
  end

  logic blank;
  assign blank = (mode == ST_STARTUP) & (hold | ov_flag);

  assign drive_a = (mode == ST_FAULT) ? FORCE_HIGH : (blank ? 1'b0 : sa[1]);
  assign drive_b = (mode == ST_FAULT) ? FORCE_HIGH : (blank ? 1'b0 : sb[1]);
  assign ref_discharge = (mode == ST_FAULT);
  assign soft_start = ss_q;

  // R4
  latch_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_discharge) |-> $past(mode == ST_NORMAL && ov_flag && ev));

  // R7
  force_level_chk: assert property (@(posedge clk) disable iff (rst)
    ref_discharge |-> (drive_a == FORCE_HIGH && drive_b == FORCE_HIGH));

  // R8
  release_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_discharge) |-> ($past(ref_low && ov_clear) && soft_start));

  // R9
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    soft_start |=> !soft_start);

  // R5
  count_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == ST_NORMAL && !ov_flag) |=> (cnt == '0));

  // R3
  startup_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == ST_STARTUP && ov_flag) |-> (!drive_a && !drive_b && !ref_discharge));
endmodule

// File: tb/ovp_supervisor_bench.sv
module ovp_supervisor_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm_a_in = 0, pwm_b_in = 0, ov_flag = 0, ov_clear = 0, ref_good = 0, ref_low = 0;
  logic drive_a, drive_b, ref_discharge, soft_start;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  ovp_supervisor u_ovp_supervisor (
    .clk(clk), .rst(rst), .pwm_a_in(pwm_a_in), .pwm_b_in(pwm_b_in),
    .ov_flag(ov_flag), .ov_clear(ov_clear), .ref_good(ref_good), .ref_low(ref_low),
    .drive_a(drive_a), .drive_b(drive_b), .ref_discharge(ref_discharge),
    .soft_start(soft_start)
  );

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // reference model of the requirements (mode 0 start-up, 1 normal, 2 fault)
  logic ma1 = 0, ma2 = 0, ma3 = 0, mb1 = 0, mb2 = 0, mb3 = 0, mhold = 0, mss = 0;
  int mmode = 0, mcnt = 0;

  function automatic logic exp_drive(logic syn);
    if (mmode == 2) return 1'b1;
    if (mmode == 0 && (mhold || ov_flag)) return 1'b0;
    return syn;
  endfunction

  always @(posedge clk) begin
    logic mev;
    mev = (ma2 & ~ma3) | (mb2 & ~mb3);
    if (rst) begin
      {ma1, ma2, ma3, mb1, mb2, mb3} <= '0;
      mmode <= 0; mcnt <= 0; mhold <= 0; mss <= 0;
    end else begin
      ma1 <= pwm_a_in; ma2 <= ma1; ma3 <= ma2;
      mb1 <= pwm_b_in; mb2 <= mb1; mb3 <= mb2;
      mss <= 0;
      if (mmode == 0) begin
        mcnt <= 0;
        if (ref_good) begin mmode <= 1; mhold <= 0; end
        else if (ov_flag) mhold <= 1;
      end else if (mmode == 1) begin
        if (!ov_flag) mcnt <= 0;
        else if (mev) begin
          if (mcnt == 4) begin mmode <= 2; mcnt <= 0; end
          else mcnt <= mcnt + 1;
        end
      end else if (ref_low && ov_clear) begin
        mmode <= 0; mss <= 1; mhold <= 0;
      end
    end
  end

  always @(posedge clk) begin
    #3;
    if (!rst) begin
      string t;
      t = (mmode == 0) ? "R2 R3 model" : (mmode == 1) ? "R4 R5 R6 model" : "R7 R8 model";
      check({t, " drive_a"}, drive_a, exp_drive(ma2));
      check({t, " drive_b"}, drive_b, exp_drive(mb2));
      check("R7 R9 model ref_discharge", ref_discharge, mmode == 2);
      check("R9 model soft_start", soft_start, mss);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #6;
  endtask

  task automatic pulse(logic a, logic b);
    pwm_a_in = a; pwm_b_in = b;
    cyc(3);
    pwm_a_in = 0; pwm_b_in = 0;
    cyc(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    cyc(3);
    check("R1 drive_a", drive_a, 0);
    check("R1 drive_b", drive_b, 0);
    check("R1 ref_discharge", ref_discharge, 0);
    check("R1 soft_start", soft_start, 0);
    rst = 0;
    cyc(1);
    pwm_a_in = 1;
    cyc(1);
    check("R2 drive_a after one edge", drive_a, 0);
    cyc(1);
    check("R2 drive_a after two edges", drive_a, 1);
    ov_flag = 1;
    #1 check("R3 immediate blank", drive_a, 0);
    cyc(1);
    ov_flag = 0;
    cyc(2);
    check("R3 hold after flag drop", drive_a, 0);
    check("R3 no discharge", ref_discharge, 0);
    ref_good = 1;
    cyc(1);
    check("R3 released in normal", drive_a, 1);
    pwm_a_in = 0;
    cyc(3);
    ov_flag = 1;
    repeat (4) pulse(1, 0);
    check("R4 four events no latch", ref_discharge, 0);
    ov_flag = 0;
    cyc(1);
    ov_flag = 1;
    repeat (4) pulse(0, 1);
    check("R5 count restarted", ref_discharge, 0);
    ov_flag = 0;
    cyc(1);
    ov_flag = 1;
    repeat (3) pulse(1, 0);
    pulse(1, 1);
    check("R6 dual edge counts once", ref_discharge, 0);
    pwm_a_in = 1;
    cyc(2);
    check("R4 not latched before count edge", ref_discharge, 0);
    cyc(1);
    check("R4 fifth event latches", ref_discharge, 1);
    pwm_a_in = 0;
    cyc(2);
    check("R7 drive_a forced", drive_a, 1);
    check("R7 drive_b forced", drive_b, 1);
    ov_flag = 0; ref_good = 0; ref_low = 1;
    cyc(3);
    check("R8 ref_low alone", ref_discharge, 1);
    ref_low = 0; ov_clear = 1;
    cyc(3);
    check("R8 ov_clear alone", ref_discharge, 1);
    ref_low = 1;
    cyc(1);
    check("R9 discharge off", ref_discharge, 0);
    check("R9 soft_start pulse", soft_start, 1);
    ref_low = 0; ov_clear = 0;
    cyc(1);
    check("R9 pulse single cycle", soft_start, 0);
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 3) == 0) pwm_a_in = ~pwm_a_in;
      if ($urandom_range(0, 3) == 0) pwm_b_in = ~pwm_b_in;
      if ($urandom_range(0, 15) == 0) ov_flag = ~ov_flag;
      if ($urandom_range(0, 11) == 0) ov_clear = ~ov_clear;
      if ($urandom_range(0, 19) == 0) ref_good = ~ref_good;
      if ($urandom_range(0, 9) == 0) ref_low = ~ref_low;
      cyc(1);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule